// File: doc/BRIEF.md
# Key-Protected Bus Grab Arbiter

This block decides which of two masters may use a single shared external-memory port. Master 0 is the privileged master and master 1 is the shared master. Each master has a request, grant and done handshake. When both masters request in normal operation, the grant alternates between them. A grant stays with its owner until that owner pulses done.

The privileged side can lock the port by writing a 32-bit configuration word. The lock bit changes only if the key field in the upper 28 bits of that same write matches a fixed pattern. While the lock is held, the shared master is stalled: it keeps its request up and receives no grant. A 32-bit counter measures how many clocks the lock has been held. When the counter reaches a programmable threshold, a timeout flag sets and the lock is released on the same edge. Software clears the timeout flag by writing 1 to it.

Top module: `grab_arbiter`

## Requirements
- R1: After reset, `cfg_rdata`, `cnt_rdata`, `timeout_flag`, `m0_gnt` and `m1_gnt` are all 0.
- R2: A configuration write whose bits 31:4 equal 28'h9EDCB4A loads bit 0 of the written data into the lock bit. The new value is visible on `cfg_rdata[0]` from the clock edge that accepts the write.
- R3: A configuration write whose bits 31:4 differ from 28'h9EDCB4A leaves the lock bit unchanged. Every write stores its bits 31:4, and `cfg_rdata[31:4]` returns the key field of the last write.
- R4: `cfg_rdata[3:1]` always reads 0, whatever value is written to those bits.
- R5: With the lock clear and both masters requesting on a free port, the master that was not granted last wins. Master 0 wins the first contest after reset.
- R6: A grant rises on the edge after the grant decision is made on a free port. It stays high until an edge at which the owner's done is 1, and then falls. The next grant can come at the edge after that.
- R7: While the lock bit is 1, `m1_gnt` never rises, and a requesting master 0 is granted.
- R8: If the lock bit goes to 1 while master 1 holds a grant, that grant stays until master 1 signals done.
- R9: `cnt_rdata` is 0 while the lock bit is 0. On each edge at which the lock stays 1, the counter increases by one, starting from 0 on the edge that sets the lock.
- R10: At an edge where the lock is 1 and `cnt_rdata` equals `timeout_thresh`, `timeout_flag` sets. On that same edge the lock bit and the counter go to 0.
- R11: Writing 1 to the status write port clears `timeout_flag`, and writing 0 leaves it as it is. If a set and a clear fall on the same edge, the set wins.
- R12: At most one of `m0_gnt` and `m1_gnt` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data: key in 31:4, lock in 0 |
| cfg_rdata | output | 32 | Configuration readback: key in 31:4, zeros in 3:1, lock in 0 |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Status write data; 1 clears the timeout flag |
| timeout_flag | output | 1 | Timeout status flag |
| timeout_thresh | input | 32 | Counter value that triggers the timeout |
| cnt_rdata | output | 32 | Lock hold-time counter |
| m0_req | input | 1 | Privileged master request |
| m0_done | input | 1 | Privileged master transfer-done strobe |
| m0_gnt | output | 1 | Privileged master grant |
| m1_req | input | 1 | Shared master request |
| m1_done | input | 1 | Shared master transfer-done strobe |
| m1_gnt | output | 1 | Shared master grant |

## Verification
Every result comes from a register, so each one is due one edge after the stimulus that causes it:
- Register writes show up on readback after the accepting edge.
- A grant appears one edge after the request meets a free port.
- A grant drops on the edge that samples done.
- Timeout, lock release and counter clear all land on the edge after the counter read equals the threshold.
- A lock release lets master 1 be granted one edge later.

The bench drives inputs on the falling edge and samples on the following falling edge. It counts edges explicitly in each scenario task, so each check lands in the exact cycle its result becomes valid.

// File: rtl/grab_arb_pkg.sv
package grab_arb_pkg;
    localparam int unsigned CFG_W = 32;
    localparam int unsigned KEY_W = 28;
    localparam int unsigned RSV_W = CFG_W - KEY_W - 1;
    localparam logic [KEY_W-1:0] LOCK_KEY = 28'h9EDCB4A;
    localparam int unsigned N_PORTS = 2;

    typedef enum logic [0:0] {
        PORT_PRIV   = 1'b0,
        PORT_SHARED = 1'b1
    } port_e;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             lock;
        logic             tmo;
    } ctrl_s;

    typedef struct packed {
        logic  busy;
        port_e owner;
        port_e last;
    } arb_s;
endpackage

// File: rtl/grab_ctrl.sv
module grab_ctrl
    import grab_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    input  logic             stat_wr_en,
    input  logic             stat_wdata,
    input  logic             tmo_hit,
    output logic [KEY_W-1:0] key_o,
    output logic             lock_q_o,
    output logic             lock_d_o,
    output logic             tmo_o
);
    ctrl_s st_q, st_d;
    logic  key_ok;

    assign key_ok = (wdata[CFG_W-1 -: KEY_W] == LOCK_KEY);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.key = wdata[CFG_W-1 -: KEY_W];
            if (key_ok) begin
                st_d.lock = wdata[0];
            end
        end
        if (stat_wr_en && stat_wdata) begin
            st_d.tmo = 1'b0;
        end
        // timeout takes precedence over both writes
        if (tmo_hit) begin
            st_d.tmo  = 1'b1;
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_o    = st_q.key;
    assign lock_q_o = st_q.lock;
    assign lock_d_o = st_d.lock;
    assign tmo_o    = st_q.tmo;
endmodule

// File: rtl/grab_timer.sv
module grab_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_q,
    input  logic             lock_d,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign hit_o = lock_q && (cnt_q == thresh);

    always_comb begin
        if (lock_q && lock_d) begin
            cnt_d = cnt_q + CNT_ONE;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/grab_rr_arb.sv
module grab_rr_arb
    import grab_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req,
    input  logic [N_PORTS-1:0] done,
    input  logic               lock,
    output logic [N_PORTS-1:0] gnt
);
    arb_s st_q, st_d;
    logic [N_PORTS-1:0] elig;

    assign elig[PORT_PRIV]   = req[PORT_PRIV];
    assign elig[PORT_SHARED] = req[PORT_SHARED] && !lock;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (done[st_q.owner]) begin
                st_d.busy = 1'b0;
            end
        end else if (elig[PORT_PRIV] && elig[PORT_SHARED]) begin
            st_d.busy  = 1'b1;
            st_d.owner = (st_q.last == PORT_PRIV) ? PORT_SHARED : PORT_PRIV;
            st_d.last  = st_d.owner;
        end else if (elig[PORT_PRIV]) begin
            st_d.busy  = 1'b1;
            st_d.owner = PORT_PRIV;
            st_d.last  = PORT_PRIV;
        end else if (elig[PORT_SHARED]) begin
            st_d.busy  = 1'b1;
            st_d.owner = PORT_SHARED;
            st_d.last  = PORT_SHARED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, owner: PORT_PRIV, last: PORT_SHARED};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_gnt
        assign gnt[i] = st_q.busy && (st_q.owner == port_e'(i));
    end
endmodule

// File: rtl/grab_arbiter.sv
module grab_arbiter
    import grab_arb_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             stat_wr_en,
    input  logic             stat_wdata,
    output logic             timeout_flag,
    input  logic [CNT_W-1:0] timeout_thresh,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             m0_req,
    input  logic             m0_done,
    output logic             m0_gnt,
    input  logic             m1_req,
    input  logic             m1_done,
    output logic             m1_gnt
);
    logic [KEY_W-1:0]   key;
    logic               lock_q, lock_d, hit;
    logic [N_PORTS-1:0] gnt;

    grab_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wdata      (cfg_wdata),
        .stat_wr_en (stat_wr_en),
        .stat_wdata (stat_wdata),
        .tmo_hit    (hit),
        .key_o      (key),
        .lock_q_o   (lock_q),
        .lock_d_o   (lock_d),
        .tmo_o      (timeout_flag)
    );

    grab_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_q (lock_q),
        .lock_d (lock_d),
        .thresh (timeout_thresh),
        .cnt_o  (cnt_rdata),
        .hit_o  (hit)
    );

    grab_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({m1_req, m0_req}),
        .done  ({m1_done, m0_done}),
        .lock  (lock_q),
        .gnt   (gnt)
    );

    assign cfg_rdata = {key, {RSV_W{1'b0}}, lock_q};
    assign m0_gnt    = gnt[PORT_PRIV];
    assign m1_gnt    = gnt[PORT_SHARED];
endmodule

// File: rtl/grab_arbiter_chk.sv
module grab_arbiter_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [31:0]      cfg_wdata,
    input logic [31:0]      cfg_rdata,
    input logic             timeout_flag,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic             m0_gnt,
    input logic             m1_gnt,
    input logic             m1_done
);
    a_r12_gnt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m0_gnt, m1_gnt}));

    a_r7_no_shared_gnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m1_gnt) |-> !$past(cfg_rdata[0]));

    a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_gnt && !m1_done) |=> m1_gnt);

    a_r9_cnt_zero_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |-> (cnt_rdata == '0));

    a_r9_cnt_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[0] && $past(cfg_rdata[0])) |-> (cnt_rdata == $past(cnt_rdata) + 1'b1));

    a_r10_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> !cfg_rdata[0]);

    a_r3_bad_key_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wdata[31:4] != 28'h9EDCB4A) |=>
            ($rose(timeout_flag) || $stable(cfg_rdata[0])));

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (cfg_rdata[3:1] == 3'b000));
endmodule

bind grab_arbiter grab_arbiter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .timeout_flag (timeout_flag),
    .cnt_rdata    (cnt_rdata),
    .m0_gnt       (m0_gnt),
    .m1_gnt       (m1_gnt),
    .m1_done      (m1_done)
);

// File: tb/grab_arbiter_tb.sv
module grab_arbiter_tb;
    localparam logic [27:0] KEY = 28'h9EDCB4A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        stat_wr_en = 1'b0;
    logic        stat_wdata = 1'b0;
    logic        timeout_flag;
    logic [31:0] timeout_thresh = 32'hFFFF_FFFF;
    logic [31:0] cnt_rdata;
    logic        m0_req = 1'b0, m0_done = 1'b0, m0_gnt;
    logic        m1_req = 1'b0, m1_done = 1'b0, m1_gnt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    grab_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .stat_wr_en(stat_wr_en), .stat_wdata(stat_wdata), .timeout_flag(timeout_flag),
        .timeout_thresh(timeout_thresh), .cnt_rdata(cnt_rdata),
        .m0_req(m0_req), .m0_done(m0_done), .m0_gnt(m0_gnt),
        .m1_req(m1_req), .m1_done(m1_done), .m1_gnt(m1_gnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [31:0] d);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        step();
        cfg_wr_en = 1'b0;
    endtask

    task automatic stat_write(input logic d);
        stat_wr_en = 1'b1;
        stat_wdata = d;
        step();
        stat_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cfg", cfg_rdata, 32'h0);
        chk("R1 cnt", cnt_rdata, 32'h0);
        chk("R1 tmo", {31'b0, timeout_flag}, 32'h0);
        chk("R1 gnt", {30'b0, m1_gnt, m0_gnt}, 32'h0);
    endtask

    task automatic t_key_and_count();
        cfg_write({KEY, 3'b111, 1'b1});
        chk("R2 lock set", cfg_rdata, {KEY, 3'b000, 1'b1});
        chk("R4 reserved", {29'b0, cfg_rdata[3:1]}, 32'h0);
        chk("R9 cnt start", cnt_rdata, 32'd0);
        repeat (5) step();
        chk("R9 cnt five", cnt_rdata, 32'd5);
        cfg_write({KEY, 3'b000, 1'b0});
        chk("R2 lock clear", {31'b0, cfg_rdata[0]}, 32'd0);
        chk("R9 cnt zero", cnt_rdata, 32'd0);
    endtask

    task automatic t_bad_key();
        cfg_write({28'h1234567, 3'b000, 1'b1});
        chk("R3 lock stays 0", {31'b0, cfg_rdata[0]}, 32'd0);
        chk("R3 key stored", {4'b0, cfg_rdata[31:4]}, 32'h1234567);
        cfg_write({KEY, 3'b000, 1'b1});
        cfg_write({28'h9EDCB4B, 3'b000, 1'b0});
        chk("R3 lock stays 1", {31'b0, cfg_rdata[0]}, 32'd1);
        cfg_write({KEY, 3'b000, 1'b0});
    endtask

    task automatic t_round_robin();
        m0_req = 1'b1; m1_req = 1'b1;
        step();
        chk("R5 first m0", {30'b0, m1_gnt, m0_gnt}, 32'b01);
        step();
        chk("R6 held", {30'b0, m1_gnt, m0_gnt}, 32'b01);
        m0_done = 1'b1; step(); m0_done = 1'b0;
        chk("R6 released", {30'b0, m1_gnt, m0_gnt}, 32'b00);
        step();
        chk("R5 then m1", {30'b0, m1_gnt, m0_gnt}, 32'b10);
        m1_done = 1'b1; step(); m1_done = 1'b0;
        step();
        chk("R5 back to m0", {30'b0, m1_gnt, m0_gnt}, 32'b01);
        m0_req = 1'b0; m1_req = 1'b0;
        m0_done = 1'b1; step(); m0_done = 1'b0;
        step();
    endtask

    task automatic t_lock_stall();
        m1_req = 1'b1;
        step();
        chk("R6 m1 alone", {30'b0, m1_gnt, m0_gnt}, 32'b10);
        cfg_write({KEY, 3'b000, 1'b1});
        m0_req = 1'b1;
        step();
        chk("R8 in flight kept", {30'b0, m1_gnt, m0_gnt}, 32'b10);
        m1_done = 1'b1; step(); m1_done = 1'b0;
        step();
        chk("R7 m0 served", {30'b0, m1_gnt, m0_gnt}, 32'b01);
        m0_req = 1'b0;
        m0_done = 1'b1; step(); m0_done = 1'b0;
        repeat (4) step();
        chk("R7 m1 stalled", {30'b0, m1_gnt, m0_gnt}, 32'b00);
        cfg_write({KEY, 3'b000, 1'b0});
        chk("R7 no gnt yet", {30'b0, m1_gnt, m0_gnt}, 32'b00);
        step();
        chk("R7 m1 after release", {30'b0, m1_gnt, m0_gnt}, 32'b10);
        m1_req = 1'b0;
        m1_done = 1'b1; step(); m1_done = 1'b0;
        step();
    endtask

    task automatic t_timeout();
        timeout_thresh = 32'd3;
        cfg_write({KEY, 3'b000, 1'b1});
        repeat (3) step();
        chk("R10 before hit cnt", cnt_rdata, 32'd3);
        chk("R10 before hit tmo", {31'b0, timeout_flag}, 32'd0);
        chk("R10 before hit lock", {31'b0, cfg_rdata[0]}, 32'd1);
        step();
        chk("R10 tmo set", {31'b0, timeout_flag}, 32'd1);
        chk("R10 lock released", {31'b0, cfg_rdata[0]}, 32'd0);
        chk("R10 cnt cleared", cnt_rdata, 32'd0);
        stat_write(1'b0);
        chk("R11 write 0 keeps", {31'b0, timeout_flag}, 32'd1);
        stat_write(1'b1);
        chk("R11 write 1 clears", {31'b0, timeout_flag}, 32'd0);
        // same-edge set and clear: set wins
        timeout_thresh = 32'd0;
        cfg_write({KEY, 3'b000, 1'b1});
        stat_write(1'b1);
        chk("R11 set wins", {31'b0, timeout_flag}, 32'd1);
        chk("R10 zero thresh lock", {31'b0, cfg_rdata[0]}, 32'd0);
        stat_write(1'b1);
        timeout_thresh = 32'hFFFF_FFFF;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        t_reset();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_key_and_count();
        t_bad_key();
        t_round_robin();
        t_lock_stall();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule